// File: doc/BRIEF.md
# Multi-Word Frame CRC Guard

This block guards frames of 18-bit parallel words on a serializer link with a cyclic redundancy check. The generator is x^7 + x^3 + 1. The transmit half passes data words through unchanged and folds each one into a 7-bit check register in a single clock. After the word that carries the end-of-frame marker, it inserts one extra check word on its output stream. The receive half folds the incoming data words into its own register. When the end-marked check word arrives, it decides whether the frame holds together.

The receive decision has three parts: the polynomial remainder of the received data bits followed by the received check bits, the padding bits of the check word, and the number of data words against the configured frame length. The receiver never corrects anything. If any part fails, it rejects the frame as a whole and raises an error flag, which upstream logic treats as a request to resend. A frame-done strobe comes with every decision.

Top module: `frame_crc_guard`

## Requirements
- R1: While reset is held, and with no transmit word offered, `outValid`, `errFlag` and `frameDone` are all 0.
- R2: A data word on the transmit input appears in the same cycle on the output, with `outData` = `txData`, `outValid` = `txValid`, `txReady` = `outReady`, `outSof` = `txSof` and `outEof` = 0.
- R3: The check word carries 11 zero bits in [17:7]. Bits [6:0] hold the remainder, modulo x^7 + x^3 + 1, of the frame's data bits times x^7. Data bits are taken first word first, bit 17 of each word first. The running value is cleared by the word that carries `txSof`.
- R4: The check word is offered with `outValid` = 1 and `outEof` = 1 from the cycle after the handshake of the `txEof` data word. It stays stable until `outReady` accepts it, and `txReady` is 0 for as long as it is offered.
- R5: On the receive side, the word that carries `rxEof` is the check word. One cycle after it is taken, `frameDone` pulses for exactly that one cycle, and `errFlag` is 0 when all three conditions hold: the frame checks clean, its padding is zero and its length matches.
- R6: `errFlag` is 1 together with `frameDone` when the remainder of the received data bits followed by check bits [6:0] is nonzero.
- R7: `errFlag` is 1 when any of check word bits [17:7] is 1.
- R8: `errFlag` is 1 when the number of data words before the check word differs from `frameLen`, including a one-word frame that carries both markers.
- R9: Every single-bit error and every error burst of up to 7 bits inside the 18*(N+1)-bit frame is flagged.
- R10: In an 8-bit-word configuration with generator x^3 + x + 1, message 10111000 gives check word 00000101. The received pair 10101000, 00000101 is flagged, and 10111000, 00000101 is accepted.
- R11: A new `rxSof` restarts the receive frame, so the words of an abandoned partial frame do not affect the next frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameLen | input | 4 | Expected data words per received frame (4 to 10) |
| txValid | input | 1 | Transmit data word valid |
| txReady | output | 1 | Transmit data word accepted |
| txData | input | 18 | Transmit data word |
| txSof | input | 1 | First word of transmit frame |
| txEof | input | 1 | Last data word of transmit frame |
| outValid | output | 1 | Link-side word valid |
| outReady | input | 1 | Link side accepts word |
| outData | output | 18 | Link-side word (data or check word) |
| outSof | output | 1 | First word of link frame |
| outEof | output | 1 | Check word marker |
| rxValid | input | 1 | Received word valid |
| rxData | input | 18 | Received word |
| rxSof | input | 1 | First word of received frame |
| rxEof | input | 1 | Received word is the check word |
| errFlag | output | 1 | Frame rejected, resend requested |
| frameDone | output | 1 | One-cycle decision strobe |

## Verification
Transmit data words are combinational, so the bench reads them 1 ns after the falling edge at which it drives them. The check word belongs to the cycle after the `txEof` handshake, and the bench reads it after the next falling edge. The receive decision is registered once at the edge that takes the check word, so the bench reads `errFlag` and `frameDone` after the following falling edge, then one cycle later confirms that the strobe has dropped. Every expected value comes from a bit-serial long division in the bench, applied to table frames, to random single, double and burst corruptions and to directed length and restart cases.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  // Strobes a control unit hands to one CRC lane of the datapath.
  typedef struct packed {
    logic load;      // fold the presented word into the lane
    logic seedZero;  // start from an all-zero value instead of the register
  } crcCtl_t;

  typedef enum logic {
    TX_DATA  = 1'b0,
    TX_CHECK = 1'b1
  } txState_e;

endpackage

// File: rtl/fcg_datapath.sv
module fcg_datapath
  import fcg_pkg::*;
#(
  parameter int              WORD_W = 18,
  parameter int              CRC_W  = 7,
  parameter logic [CRC_W-1:0] POLY  = 7'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcCtl_t           txCtl,
  input  logic              selCheck,
  input  logic [WORD_W-1:0] txData,
  output logic [WORD_W-1:0] outData,
  input  crcCtl_t           rxCtl,
  input  logic [WORD_W-1:0] rxData,
  output logic [CRC_W-1:0]  rxSyndrome,
  output logic              rxPadBad
);

  localparam int PAD_W = WORD_W - CRC_W;

  // Unrolled division step: one whole word, most significant bit first.
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] seed,
                                               input logic [WORD_W-1:0] word);
    logic [CRC_W-1:0] c;
    logic fb;
    c = seed;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  logic [CRC_W-1:0] txCrc, rxCrc;
  logic [CRC_W-1:0] txBase, rxBase;

  assign txBase = txCtl.seedZero ? '0 : txCrc;
  assign rxBase = rxCtl.seedZero ? '0 : rxCrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCrc <= '0;
      rxCrc <= '0;
    end else begin
      if (txCtl.load) txCrc <= crcStep(txBase, txData);
      if (rxCtl.load) rxCrc <= crcStep(rxBase, rxData);
    end
  end

  assign outData    = selCheck ? {{PAD_W{1'b0}}, txCrc} : txData;
  assign rxSyndrome = rxBase ^ rxData[CRC_W-1:0];
  assign rxPadBad   = |rxData[WORD_W-1:CRC_W];

endmodule

// File: rtl/fcg_tx_ctrl.sv
module fcg_tx_ctrl
  import fcg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txValid,
  input  logic    txSof,
  input  logic    txEof,
  input  logic    outReady,
  output logic    txReady,
  output logic    outValid,
  output logic    outSof,
  output logic    outEof,
  output logic    selCheck,
  output crcCtl_t txCtl
);

  txState_e state, stateNext;

  always_comb begin
    stateNext = state;
    txCtl     = '0;
    txReady   = 1'b0;
    outValid  = 1'b0;
    outSof    = 1'b0;
    outEof    = 1'b0;
    selCheck  = 1'b0;
    case (state)
      TX_DATA: begin
        outValid = txValid;
        txReady  = outReady;
        outSof   = txSof;
        if (txValid && outReady) begin
          txCtl.load     = 1'b1;
          txCtl.seedZero = txSof;
          if (txEof) stateNext = TX_CHECK;
        end
      end
      TX_CHECK: begin
        outValid = 1'b1;
        outEof   = 1'b1;
        selCheck = 1'b1;
        if (outReady) stateNext = TX_DATA;
      end
      default: stateNext = TX_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= TX_DATA;
    else       state <= stateNext;
  end

endmodule

// File: rtl/fcg_rx_ctrl.sv
module fcg_rx_ctrl
  import fcg_pkg::*;
#(
  parameter int CRC_W = 7,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             rxValid,
  input  logic             rxSof,
  input  logic             rxEof,
  input  logic [CRC_W-1:0] rxSyndrome,
  input  logic             rxPadBad,
  output crcCtl_t          rxCtl,
  output logic             errFlag,
  output logic             frameDone
);

  logic [LEN_W-1:0] wordCnt;
  logic [LEN_W-1:0] dataWords;
  logic             badFrame;

  always_comb begin
    rxCtl.load     = rxValid && !rxEof;
    rxCtl.seedZero = rxSof;
  end

  assign dataWords = rxSof ? '0 : wordCnt;
  assign badFrame  = (dataWords != frameLen) || rxPadBad || (rxSyndrome != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt   <= '0;
      errFlag   <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      errFlag   <= 1'b0;
      frameDone <= 1'b0;
      if (rxValid) begin
        if (rxEof) begin
          frameDone <= 1'b1;
          errFlag   <= badFrame;
          wordCnt   <= '0;
        end else if (rxSof) begin
          wordCnt <= LEN_W'(1);
        end else if (wordCnt != '1) begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/frame_crc_guard.sv
module frame_crc_guard
  import fcg_pkg::*;
#(
  parameter int               WORD_W = 18,
  parameter int               CRC_W  = 7,
  parameter logic [CRC_W-1:0] POLY   = 7'h09,
  parameter int               LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txData,
  input  logic              txSof,
  input  logic              txEof,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              outSof,
  output logic              outEof,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxData,
  input  logic              rxSof,
  input  logic              rxEof,
  output logic              errFlag,
  output logic              frameDone
);

  crcCtl_t          txCtl, rxCtl;
  logic             selCheck;
  logic [CRC_W-1:0] rxSyndrome;
  logic             rxPadBad;

  fcg_tx_ctrl u_txCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .txValid  (txValid),
    .txSof    (txSof),
    .txEof    (txEof),
    .outReady (outReady),
    .txReady  (txReady),
    .outValid (outValid),
    .outSof   (outSof),
    .outEof   (outEof),
    .selCheck (selCheck),
    .txCtl    (txCtl)
  );

  fcg_rx_ctrl #(.CRC_W(CRC_W), .LEN_W(LEN_W)) u_rxCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameLen   (frameLen),
    .rxValid    (rxValid),
    .rxSof      (rxSof),
    .rxEof      (rxEof),
    .rxSyndrome (rxSyndrome),
    .rxPadBad   (rxPadBad),
    .rxCtl      (rxCtl),
    .errFlag    (errFlag),
    .frameDone  (frameDone)
  );

  fcg_datapath #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .txCtl      (txCtl),
    .selCheck   (selCheck),
    .txData     (txData),
    .outData    (outData),
    .rxCtl      (rxCtl),
    .rxData     (rxData),
    .rxSyndrome (rxSyndrome),
    .rxPadBad   (rxPadBad)
  );

endmodule

// File: rtl/frame_crc_guard_chk.sv
module frame_crc_guard_chk #(
  parameter int WORD_W = 18,
  parameter int CRC_W  = 7,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [LEN_W-1:0]  frameLen,
  input logic              txReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              outEof,
  input logic              rxValid,
  input logic              rxSof,
  input logic              rxEof,
  input logic              errFlag,
  input logic              frameDone
);

  // R3
  check_pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> (outData[WORD_W-1:CRC_W] == '0));

  // R4
  check_word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEof && !outReady) |=> (outValid && outEof && $stable(outData)));

  // R4
  input_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> !txReady);

  // R5
  done_after_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(rxValid && rxEof));

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> frameDone);

  // R8
  lone_word_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof && rxEof && frameLen != '0) |=> errFlag);

endmodule

bind frame_crc_guard frame_crc_guard_chk #(
  .WORD_W(WORD_W), .CRC_W(CRC_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .frameLen(frameLen), .txReady(txReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outEof(outEof),
  .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
  .errFlag(errFlag), .frameDone(frameDone)
);

// File: tb/test_frame_crc_guard.sv
`timescale 1ns/1ps
module test_frame_crc_guard;
  localparam int W  = 18;
  localparam int C  = 7;
  localparam int LW = 4;
  localparam int VEC_N = 6;
  // {length[31:24], seed[23:8], flipped stream bit[7:0]; 255 = none}
  localparam logic [31:0] VECS [VEC_N] = '{
    {8'd4,  16'h0001, 8'd255},
    {8'd10, 16'h1234, 8'd255},
    {8'd7,  16'h00AB, 8'd0},
    {8'd10, 16'h0F0F, 8'd193},
    {8'd5,  16'h7777, 8'd94},
    {8'd8,  16'h00FF, 8'd150}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LW-1:0] frameLen;
  logic txValid, txReady, txSof, txEof, outValid, outReady, outSof, outEof;
  logic [W-1:0] txData, outData, rxData;
  logic rxValid, rxSof, rxEof, errFlag, frameDone;

  logic [LW-1:0] sLen;
  logic sTxValid, sTxReady, sTxSof, sTxEof, sOutValid, sOutReady, sOutSof, sOutEof;
  logic [7:0] sTxData, sOutData, sRxData;
  logic sRxValid, sRxSof, sRxEof, sErr, sDone;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] frameWords [0:15];
  logic [W-1:0] origWords  [0:15];
  logic bitStream [0:255];

  always #4 clk = ~clk;

  frame_crc_guard i_frame_crc_guard (
    .clk(clk), .rstN(rstN), .frameLen(frameLen),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txSof(txSof), .txEof(txEof),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSof(outSof), .outEof(outEof),
    .rxValid(rxValid), .rxData(rxData), .rxSof(rxSof), .rxEof(rxEof),
    .errFlag(errFlag), .frameDone(frameDone)
  );

  frame_crc_guard #(.WORD_W(8), .CRC_W(3), .POLY(3'b011), .LEN_W(LW)) i_frame_crc_guard_small (
    .clk(clk), .rstN(rstN), .frameLen(sLen),
    .txValid(sTxValid), .txReady(sTxReady), .txData(sTxData), .txSof(sTxSof), .txEof(sTxEof),
    .outValid(sOutValid), .outReady(sOutReady), .outData(sOutData), .outSof(sOutSof), .outEof(sOutEof),
    .rxValid(sRxValid), .rxData(sRxData), .rxSof(sRxSof), .rxEof(sRxEof),
    .errFlag(sErr), .frameDone(sDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Plain long division of the loaded bit stream by 1_0001001.
  function automatic logic [6:0] refDivide(input int nBits);
    logic [7:0] r = '0;
    for (int i = 0; i < nBits; i++) begin
      r = {r[6:0], bitStream[i]};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic void loadStream(input int nData, input bit withCheck);
    for (int k = 0; k < nData; k++)
      for (int b = 0; b < W; b++) bitStream[k*W+b] = frameWords[k][W-1-b];
    for (int b = 0; b < C; b++) bitStream[nData*W+b] = withCheck ? frameWords[nData][C-1-b] : 1'b0;
  endfunction

  function automatic bit expectRxErr(input int nTotal);
    loadStream(nTotal - 1, 1'b1);
    return (refDivide((nTotal - 1) * W + C) != '0) ||
           (frameWords[nTotal-1][W-1:C] != '0) ||
           ((nTotal - 1) != int'(frameLen));
  endfunction

  task automatic flipBit(input int pos);
    frameWords[pos / W][W - 1 - (pos % W)] ^= 1'b1;
  endtask

  task automatic sendTx(input int n, input int seed, input bit stall);
    logic [W-1:0] w, held;
    logic [6:0] expCrc;
    bit passOk = 1'b1;
    for (int k = 0; k < n; k++) begin
      w = W'(seed * 7919 + k * 104729 + k * k * 31337);
      @(negedge clk);
      txValid = 1'b1; txData = w; txSof = (k == 0); txEof = (k == n - 1); outReady = 1'b1;
      #1;
      if (outData !== w || outValid !== 1'b1 || txReady !== 1'b1 ||
          outSof !== (k == 0) || outEof !== 1'b0) passOk = 1'b0;
      frameWords[k] = w;
      @(posedge clk);
    end
    check(passOk, "R2 pass-through", {31'd0, passOk}, 32'd1);
    @(negedge clk);
    txValid = 1'b0; txSof = 1'b0; txEof = 1'b0;
    if (stall) begin
      outReady = 1'b0;
      #1;
      check(outValid && outEof && !txReady, "R4 check word offered",
            {outValid, outEof, txReady}, 3'b110);
      held = outData;
      @(negedge clk);
      #1;
      check(outValid && outEof && outData === held, "R4 check word held", outData, held);
      outReady = 1'b1;
    end
    #1;
    check(outValid && outEof && !txReady, "R4 check word", {outValid, outEof, txReady}, 3'b110);
    frameWords[n] = outData;
    loadStream(n, 1'b0);
    expCrc = refDivide(n * W + C);
    check(outData === {{(W-C){1'b0}}, expCrc}, "R3 check word value", outData, expCrc);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(outValid === 1'b0, "R4 back to data", outValid, 0);
  endtask

  task automatic sendRx(input int nTotal, input bit expErr, input string req);
    for (int k = 0; k < nTotal; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = frameWords[k]; rxSof = (k == 0); rxEof = (k == nTotal - 1);
      @(posedge clk);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    #1;
    check(frameDone === 1'b1, req, frameDone, 1);
    check(errFlag === expErr, req, errFlag, expErr);
    @(negedge clk);
    #1;
    check(frameDone === 1'b0 && errFlag === 1'b0, "R5 strobe width", {frameDone, errFlag}, 0);
  endtask

  task automatic rxSmall(input logic [7:0] a, input logic [7:0] b, input bit expErr);
    @(negedge clk); sRxValid = 1'b1; sRxData = a; sRxSof = 1'b1; sRxEof = 1'b0;
    @(posedge clk);
    @(negedge clk); sRxData = b; sRxSof = 1'b0; sRxEof = 1'b1;
    @(posedge clk);
    @(negedge clk); sRxValid = 1'b0; sRxEof = 1'b0;
    #1;
    check(sDone === 1'b1 && sErr === expErr, "R10 small receive", {sDone, sErr}, {1'b1, expErr});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit e;
    int len, flip, pos, bl, st, p2;
    frameLen = 4'd4; txValid = 0; txSof = 0; txEof = 0; txData = '0; outReady = 1'b1;
    rxValid = 0; rxSof = 0; rxEof = 0; rxData = '0;
    sLen = 4'd1; sTxValid = 0; sTxSof = 0; sTxEof = 0; sTxData = '0; sOutReady = 1'b1;
    sRxValid = 0; sRxSof = 0; sRxEof = 0; sRxData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(outValid === 1'b0 && errFlag === 1'b0 && frameDone === 1'b0, "R1 reset",
          {outValid, errFlag, frameDone}, 0);
    rstN = 1'b1;

    // Table of frames, each optionally with one flipped bit.
    for (int v = 0; v < VEC_N; v++) begin
      len  = int'(VECS[v][31:24]);
      flip = int'(VECS[v][7:0]);
      frameLen = LW'(len);
      sendTx(len, int'(VECS[v][23:8]), v == 1);
      if (flip != 255) flipBit(flip);
      e = expectRxErr(len + 1);
      check(e == (flip != 255), "R9 single flip reference", e, flip != 255);
      if (flip == 255)               sendRx(len + 1, e, "R5 clean frame");
      else if (flip % W >= W - C)    sendRx(len + 1, e, "R6 remainder error");
      else if (flip >= len * W)      sendRx(len + 1, e, "R7 pad error");
      else                           sendRx(len + 1, e, "R6 remainder error");
    end

    // R7: directed padding corruption on a fresh frame.
    frameLen = 4'd6;
    sendTx(6, 77, 1'b0);
    frameWords[6][W-1] ^= 1'b1;
    sendRx(7, 1'b1, "R7 pad bit 17");

    // R9: random single, burst and double errors on one ten-word frame.
    frameLen = 4'd10;
    sendTx(10, 16'h05A5, 1'b0);
    for (int k = 0; k <= 10; k++) origWords[k] = frameWords[k];
    for (int t = 0; t < 90; t++) begin
      for (int k = 0; k <= 10; k++) frameWords[k] = origWords[k];
      if (t % 3 == 0) begin
        pos = int'($urandom_range(197, 0));
        flipBit(pos);
        e = expectRxErr(11);
        check(e, "R9 single reference", e, 1);
        sendRx(11, 1'b1, "R9 single");
      end else if (t % 3 == 1) begin
        bl = int'($urandom_range(7, 2));
        st = int'($urandom_range(198 - bl, 0));
        flipBit(st);
        flipBit(st + bl - 1);
        for (int i = st + 1; i < st + bl - 1; i++) if ($urandom_range(1, 0) == 1) flipBit(i);
        e = expectRxErr(11);
        check(e, "R9 burst reference", e, 1);
        sendRx(11, 1'b1, "R9 burst");
      end else begin
        pos = int'($urandom_range(197, 0));
        p2 = (pos + 1 + int'($urandom_range(196, 0))) % 198;
        flipBit(pos);
        flipBit(p2);
        e = expectRxErr(11);
        sendRx(11, e, "R6 double");
      end
    end

    // R8: length mismatches with a valid remainder.
    frameLen = 4'd8;
    sendTx(6, 31, 1'b0);
    sendRx(7, 1'b1, "R8 short frame");
    sendTx(9, 32, 1'b0);
    sendRx(10, 1'b1, "R8 long frame");
    frameWords[0] = '0;
    sendRx(1, 1'b1, "R8 lone check word");

    // R11: abandoned partial frame followed by a restart.
    frameLen = 4'd5;
    sendTx(5, 51, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = W'(18'h2AAAA ^ k); rxSof = (k == 0); rxEof = 1'b0;
      @(posedge clk);
    end
    sendRx(6, 1'b0, "R11 restart");

    // R10: small configuration test vector.
    @(negedge clk);
    sLen = 4'd1; sTxValid = 1'b1; sTxData = 8'hB8; sTxSof = 1'b1; sTxEof = 1'b1; sOutReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sTxValid = 1'b0; sTxSof = 1'b0; sTxEof = 1'b0;
    #1;
    check(sOutEof === 1'b1 && sOutData === 8'h05, "R10 small check word", sOutData, 8'h05);
    @(posedge clk);
    rxSmall(8'hA8, 8'h05, 1'b1);
    rxSmall(8'hB8, 8'h05, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule